// File: doc/BRIEF.md
# Transient trip window detector

This block watches digitized output-voltage samples of a multi-phase regulator. It raises a fast override when a sample leaves a window around the target voltage. The window is derived from a target code and two 4-bit offset words, one upward and one downward. One code LSB is 7.5 mV for both the target and the sample, so the offsets add to the target directly.

The block is configured through a small register write port while it is disabled, before soft start. After `en_i` goes high, each valid sample is compared against the upper and lower trip levels. A sample below the window puts the PWM side into align-all-phases mode to raise the output. A sample above the window puts it into remove-all-phases mode to lower the output. The reaction takes effect on the clock edge that captures the sample. The override lasts while the trip condition persists, plus a programmable number of hold cycles, and then returns to normal.

Top module: `trip_window_top`

## Requirements
- R1: After reset, both trip flags are 0, `mode_o` is normal (2'b00), and the target, offset and hold registers are 0.
- R2: A write with `en_i` low loads one register. Address 0 loads the target code. Address 1 loads the offsets: bits [7:4] are the high offset and bits [3:0] are the low offset. Address 2 loads the hold count. Writes while `en_i` is high are ignored.
- R3: The upper level is target plus high offset, saturated at the maximum code. `trip_hi_o` is set when a valid sample is strictly greater than the upper level.
- R4: The lower level is target minus low offset, saturated at 0. `trip_lo_o` is set when a valid sample is strictly less than the lower level.
- R5: The trip flags update only on edges where `sample_valid_i` is high. Otherwise they hold their value.
- R6: A low trip sets `mode_o` to align-all (2'b01) on the same edge that captures the sample.
- R7: A high trip sets `mode_o` to remove-all (2'b10) on the same edge that captures the sample.
- R8: After the trip condition clears, `mode_o` keeps its override value for exactly the programmed hold count of cycles, then returns to normal. A hold count of 0 returns it on the clearing edge.
- R9: A trip of the opposite direction during an override or its hold switches `mode_o` at once and restarts the hold. If both conditions are active together, the low trip wins.
- R10: While `en_i` is low, the trip flags are 0 and `mode_o` is normal from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Enables detection; blocks register writes when high |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address (0 target, 1 offsets, 2 hold) |
| wr_data_i | input | CODE_W | Register write data |
| sample_valid_i | input | 1 | Sample qualifier |
| sample_i | input | CODE_W | Digitized output-voltage code, 7.5 mV LSB |
| trip_hi_o | output | 1 | Sample above upper trip level |
| trip_lo_o | output | 1 | Sample below lower trip level |
| mode_o | output | 2 | Override mode: 00 normal, 01 align all, 10 remove all |

## Verification
The assertions take for granted that configuration happens only while `en_i` is low. They also take for granted that the hold count is stable during operation, and that `sample_i` is meaningful only on cycles where `sample_valid_i` is high. The stimulus drops `en_i` before every register change and holds it low across each write. It pulses `sample_valid_i` for single cycles on the falling clock edge, so every comparison sees a settled sample against settled levels. Writes with `en_i` high are issued only to show that they are ignored.

// File: rtl/trip_pkg.sv
package trip_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_ALIGN  = 2'b01,
    MODE_REMOVE = 2'b10
  } ovr_mode_e;

  localparam logic [1:0] ADDR_TARGET = 2'd0;
  localparam logic [1:0] ADDR_OFFS   = 2'd1;
  localparam logic [1:0] ADDR_HOLD   = 2'd2;
endpackage

// File: rtl/trip_cfg_regs.sv
module trip_cfg_regs #(
  parameter int CODE_W = 8,
  parameter int OFS_W  = 4,
  parameter int HOLD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [CODE_W-1:0] wr_data_i,
  output logic [CODE_W-1:0] target_o,
  output logic [OFS_W-1:0]  ofs_hi_o,
  output logic [OFS_W-1:0]  ofs_lo_o,
  output logic [HOLD_W-1:0] hold_o
);
  import trip_pkg::*;

  logic wr_ok;
  assign wr_ok = wr_en_i && !en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      target_o <= '0;
      ofs_hi_o <= '0;
      ofs_lo_o <= '0;
      hold_o   <= '0;
    end else if (wr_ok) begin
      case (wr_addr_i)
        ADDR_TARGET: target_o <= wr_data_i;
        ADDR_OFFS: begin
          ofs_hi_o <= wr_data_i[2*OFS_W-1:OFS_W];
          ofs_lo_o <= wr_data_i[OFS_W-1:0];
        end
        ADDR_HOLD: hold_o <= wr_data_i[HOLD_W-1:0];
        default: ;
      endcase
    end
  end

  // R2: configuration frozen while enabled
  a_r2_frozen_when_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> ($stable(target_o) && $stable(ofs_hi_o) && $stable(ofs_lo_o) && $stable(hold_o)));
endmodule

// File: rtl/trip_level_calc.sv
module trip_level_calc #(
  parameter int CODE_W = 8,
  parameter int OFS_W  = 4
) (
  input  logic [CODE_W-1:0] target_i,
  input  logic [OFS_W-1:0]  ofs_hi_i,
  input  logic [OFS_W-1:0]  ofs_lo_i,
  output logic [CODE_W-1:0] upper_o,
  output logic [CODE_W-1:0] lower_o
);
  localparam int PAD_W = CODE_W + 1 - OFS_W;

  logic [CODE_W:0] sum_w;
  logic [CODE_W:0] diff_w;

  always_comb begin
    sum_w  = {1'b0, target_i} + {{PAD_W{1'b0}}, ofs_hi_i};
    diff_w = {1'b0, target_i} - {{PAD_W{1'b0}}, ofs_lo_i};
    // carry or borrow out means the level left the code range
    upper_o = sum_w[CODE_W]  ? {CODE_W{1'b1}} : sum_w[CODE_W-1:0];
    lower_o = diff_w[CODE_W] ? {CODE_W{1'b0}} : diff_w[CODE_W-1:0];
  end
endmodule

// File: rtl/trip_detect.sv
module trip_detect #(
  parameter int CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sample_valid_i,
  input  logic [CODE_W-1:0] sample_i,
  input  logic [CODE_W-1:0] upper_i,
  input  logic [CODE_W-1:0] lower_i,
  output logic              hi_act_o,
  output logic              lo_act_o,
  output logic              trip_hi_o,
  output logic              trip_lo_o
);
  logic hi_now, lo_now;

  assign hi_now = sample_i > upper_i;
  assign lo_now = sample_i < lower_i;

  // effective condition this cycle: fresh compare on a valid sample, else held flag
  assign hi_act_o = en_i && (sample_valid_i ? hi_now : trip_hi_o);
  assign lo_act_o = en_i && (sample_valid_i ? lo_now : trip_lo_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trip_hi_o <= 1'b0;
      trip_lo_o <= 1'b0;
    end else if (!en_i) begin
      trip_hi_o <= 1'b0;
      trip_lo_o <= 1'b0;
    end else if (sample_valid_i) begin
      trip_hi_o <= hi_now;
      trip_lo_o <= lo_now;
    end
  end

  a_r3_hi_trip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sample_valid_i && (sample_i > upper_i)) |=> trip_hi_o);
  a_r4_lo_trip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sample_valid_i && (sample_i < lower_i)) |=> trip_lo_o);
  a_r5_hold_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !sample_valid_i) |=> ($stable(trip_hi_o) && $stable(trip_lo_o)));
  a_r10_flags_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!trip_hi_o && !trip_lo_o));
endmodule

// File: rtl/trip_override_fsm.sv
module trip_override_fsm #(
  parameter int HOLD_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic                   hi_act_i,
  input  logic                   lo_act_i,
  input  logic [HOLD_W-1:0]      hold_i,
  output trip_pkg::ovr_mode_e    mode_o
);
  import trip_pkg::*;

  ovr_mode_e        state_q;
  logic [HOLD_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MODE_NORMAL;
      cnt_q   <= '0;
    end else if (!en_i) begin
      state_q <= MODE_NORMAL;
      cnt_q   <= '0;
    end else if (lo_act_i) begin
      // low trip has priority
      state_q <= MODE_ALIGN;
      cnt_q   <= hold_i;
    end else if (hi_act_i) begin
      state_q <= MODE_REMOVE;
      cnt_q   <= hold_i;
    end else if (state_q != MODE_NORMAL) begin
      if (cnt_q == '0) state_q <= MODE_NORMAL;
      else             cnt_q   <= cnt_q - 1'b1;
    end
  end

  assign mode_o = state_q;

  a_r6_align_on_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && lo_act_i) |=> (mode_o == MODE_ALIGN));
  a_r7_remove_on_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && hi_act_i && !lo_act_i) |=> (mode_o == MODE_REMOVE));
  a_r8_stay_during_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !hi_act_i && !lo_act_i && (state_q != MODE_NORMAL) && (cnt_q != '0))
    |=> $stable(state_q));
  a_r10_normal_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (mode_o == MODE_NORMAL));
endmodule

// File: rtl/trip_window_top.sv
module trip_window_top #(
  parameter int CODE_W = 8,
  parameter int OFS_W  = 4,
  parameter int HOLD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [CODE_W-1:0] wr_data_i,
  input  logic              sample_valid_i,
  input  logic [CODE_W-1:0] sample_i,
  output logic              trip_hi_o,
  output logic              trip_lo_o,
  output logic [1:0]        mode_o
);
  logic [CODE_W-1:0] target_w, upper_w, lower_w;
  logic [OFS_W-1:0]  ofs_hi_w, ofs_lo_w;
  logic [HOLD_W-1:0] hold_w;
  logic              hi_act_w, lo_act_w;
  trip_pkg::ovr_mode_e mode_w;

  trip_cfg_regs #(.CODE_W(CODE_W), .OFS_W(OFS_W), .HOLD_W(HOLD_W)) u_cfg (
    .clk_i, .rst_ni, .en_i, .wr_en_i, .wr_addr_i, .wr_data_i,
    .target_o(target_w), .ofs_hi_o(ofs_hi_w), .ofs_lo_o(ofs_lo_w), .hold_o(hold_w)
  );

  trip_level_calc #(.CODE_W(CODE_W), .OFS_W(OFS_W)) u_calc (
    .target_i(target_w), .ofs_hi_i(ofs_hi_w), .ofs_lo_i(ofs_lo_w),
    .upper_o(upper_w), .lower_o(lower_w)
  );

  trip_detect #(.CODE_W(CODE_W)) u_det (
    .clk_i, .rst_ni, .en_i, .sample_valid_i, .sample_i,
    .upper_i(upper_w), .lower_i(lower_w),
    .hi_act_o(hi_act_w), .lo_act_o(lo_act_w),
    .trip_hi_o, .trip_lo_o
  );

  trip_override_fsm #(.HOLD_W(HOLD_W)) u_fsm (
    .clk_i, .rst_ni, .en_i, .hi_act_i(hi_act_w), .lo_act_i(lo_act_w),
    .hold_i(hold_w), .mode_o(mode_w)
  );

  assign mode_o = mode_w;

  // R9: the two trip outputs never rise together
  a_r9_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(trip_hi_o && trip_lo_o));
endmodule

// File: tb/trip_window_top_tb.sv
`timescale 1ns/1ps
module trip_window_top_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       sample_valid_i = 1'b0;
  logic [7:0] sample_i = '0;
  logic       trip_hi_o, trip_lo_o;
  logic [1:0] mode_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  localparam logic [1:0] M_NORM = 2'b00, M_ALIGN = 2'b01, M_REMOVE = 2'b10;

  always #2.5 clk = ~clk;

  trip_window_top u_dut (
    .clk_i(clk), .rst_ni, .en_i, .wr_en_i, .wr_addr_i, .wr_data_i,
    .sample_valid_i, .sample_i, .trip_hi_o, .trip_lo_o, .mode_o
  );

  task automatic chk(input string req, input logic [1:0] m, input logic hi, input logic lo);
    n_run++;
    if (mode_o !== m || trip_hi_o !== hi || trip_lo_o !== lo) begin
      n_fail++;
      $display("FAIL %s: got mode=%b hi=%b lo=%b, expected mode=%b hi=%b lo=%b",
               req, mode_o, trip_hi_o, trip_lo_o, m, hi, lo);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic put(input logic [7:0] s);
    sample_i = s; sample_valid_i = 1'b1;
    @(negedge clk);
    sample_valid_i = 1'b0;
  endtask

  task automatic setup(input logic [7:0] tgt, input logic [7:0] ofs, input logic [7:0] hold);
    en_i = 1'b0;
    @(negedge clk);
    wr(2'd0, tgt); wr(2'd1, ofs); wr(2'd2, hold);
    en_i = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 reset", M_NORM, 0, 0);
    rst_ni = 1'b1;
    en_i = 1'b1;
    put(8'd1); // all-zero config: upper 0, sample 1 above it
    chk("R1 zero config gives upper level 0", M_REMOVE, 1, 0);
    en_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_high;
    setup(8'd100, 8'h43, 8'd3);
    put(8'd104);
    chk("R3 equal to upper level, no trip", M_NORM, 0, 0);
    put(8'd105);
    chk("R7 above upper level removes phases", M_REMOVE, 1, 0);
    put(8'd100);
    chk("R8 hold cycle 1", M_REMOVE, 0, 0);
    @(negedge clk); chk("R8 hold cycle 2", M_REMOVE, 0, 0);
    @(negedge clk); chk("R8 hold cycle 3", M_REMOVE, 0, 0);
    @(negedge clk); chk("R8 back to normal after hold", M_NORM, 0, 0);
  endtask

  task automatic t_low_switch;
    put(8'd97);
    chk("R4 equal to lower level, no trip", M_NORM, 0, 0);
    put(8'd96);
    chk("R6 below lower level aligns phases", M_ALIGN, 0, 1);
    put(8'd110);
    chk("R9 opposite trip switches mode", M_REMOVE, 1, 0);
    sample_i = 8'd100;
    @(negedge clk);
    chk("R5 flags held without valid", M_REMOVE, 1, 0);
    put(8'd100);
    repeat (4) @(negedge clk);
    chk("R8 normal after clear and hold", M_NORM, 0, 0);
  endtask

  task automatic t_blocked_write;
    wr(2'd0, 8'd0); // ignored while enabled
    put(8'd50);
    chk("R2 write blocked while enabled", M_ALIGN, 0, 1);
    put(8'd100);
    repeat (4) @(negedge clk);
    chk("R2 settle", M_NORM, 0, 0);
  endtask

  task automatic t_disable;
    put(8'd50);
    chk("R10 pre-disable low trip", M_ALIGN, 0, 1);
    en_i = 1'b0;
    @(negedge clk);
    chk("R10 disable forces normal", M_NORM, 0, 0);
  endtask

  task automatic t_saturate;
    setup(8'd250, 8'hFF, 8'd0);
    put(8'd255);
    chk("R3 upper saturates at max code", M_NORM, 0, 0);
    setup(8'd5, 8'hFF, 8'd0);
    put(8'd0);
    chk("R4 lower saturates at zero", M_NORM, 0, 0);
    setup(8'd250, 8'h30, 8'd0);
    put(8'd254);
    chk("R3 high offset from nibble [7:4]", M_REMOVE, 1, 0);
  endtask

  task automatic t_zero_hold;
    setup(8'd100, 8'h43, 8'd0);
    put(8'd96);
    chk("R6 align with zero hold", M_ALIGN, 0, 1);
    put(8'd100);
    chk("R8 zero hold returns on clearing edge", M_NORM, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_high;
    t_low_switch;
    t_blocked_write;
    t_disable;
    t_saturate;
    t_zero_hold;
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule